// File: doc/BRIEF.md
# Cross-Bank Priority Interrupt Encoder

This block turns three bytes of already-masked interrupt requests into the number of the single interrupt that should be serviced next. The three request groups are a high group, a DMA group and a low group. A handler reads the encoded number, services that source, and asks again until the result is zero.

The groups are searched in a fixed rank: the high group first, then the DMA group, then the low group. The first group with any request bit set decides the result. Inside each group the bits are not ranked by position. Each group has its own fixed, irregular ranking. The result is a 5-bit interrupt number and a valid flag, both registered one clock after the request inputs are sampled.

Interrupt number zero means "nothing pending". Low-group bit 0 maps to number 0, so a pending request on that bit reads as no interrupt. It still ends the search, and so it hides low-group bits 1 and 4, which rank below it.

Top module: `irq_prio_enc`

## Requirements
- R1: When any bit of `req_hi` is set, the result comes from the high group: number 8+n for one of its set bits n, whatever the other groups hold.
- R2: When `req_hi` is zero and any bit of `req_dma` is set, the result is 16+n for one of the DMA group's set bits n, whatever `req_lo` holds.
- R3: When `req_hi` and `req_dma` are both zero, the result is n for a set bit n of `req_lo`, or 0 when `req_lo` is zero.
- R4: High-group bits rank, from highest to lowest: 2, 3, 5, 7, 6, 0, 1, 4.
- R5: DMA-group bits rank, from highest to lowest: 0, 1, 2, 3, 5, 6, 7, 4.
- R6: Low-group bits rank, from highest to lowest: 7, 5, 3, 6, 2, 0, 1, 4.
- R7: Low-group bit 0 encodes as number 0. When it is the highest-ranked set low bit and the other groups are empty, the result is 0 with valid low, even if bits 1 or 4 are also set.
- R8: `irq_valid` is 1 exactly when `irq_num` is nonzero.
- R9: `irq_num` and `irq_valid` show the encoding of the request inputs sampled at the previous rising clock edge.
- R10: While `rst` is high at a rising edge, both outputs become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 8 | Masked requests of the high group (numbers 8..15) |
| req_dma | input | 8 | Masked requests of the DMA group (numbers 16..23) |
| req_lo | input | 8 | Masked requests of the low group (numbers 0..7) |
| irq_num | output | 5 | Number of the highest-ranked pending interrupt, 0 when none |
| irq_valid | output | 1 | Set when `irq_num` is nonzero |

## Verification
The assertions assume the request bytes are stable across each rising edge, with no X values, so that the inputs sampled at one edge decide the outputs seen after the next. The stimulus changes the inputs only on falling edges and always drives all three bytes to known values. Reset is applied only at a falling edge, with the inputs left defined. The directed vectors cover every single bit, every adjacent pair in each ranking, cross-group mixes, and low bit 0 with bits 1 and 4. A long run of pseudo-random bytes, some with whole groups forced to zero, covers the remaining combinations of group emptiness.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int ID_W      = 5;
    localparam int IDX_W     = $clog2(BANK_W);

    // Rank r of a group lives at bits [r*IDX_W +: IDX_W]; rank 0 is highest.
    typedef logic [BANK_W*IDX_W-1:0] order_t;

    localparam order_t ORDER_HI  = {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2};
    localparam order_t ORDER_DMA = {3'd4, 3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
    localparam order_t ORDER_LO  = {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};

    localparam int BASE_HI  = 8;
    localparam int BASE_DMA = 16;
    localparam int BASE_LO  = 0;

    // Search rank of the groups: lower index wins.
    typedef enum logic [1:0] {
        GRP_HI  = 2'd0,
        GRP_DMA = 2'd1,
        GRP_LO  = 2'd2
    } grp_e;

    typedef struct packed {
        logic            hit;  // group had any request: search stops here
        logic [ID_W-1:0] id;   // encoded number (may be zero)
    } grp_res_t;

    function automatic order_t order_of(input int g);
        case (g)
            int'(GRP_HI):  return ORDER_HI;
            int'(GRP_DMA): return ORDER_DMA;
            default:       return ORDER_LO;
        endcase
    endfunction

    function automatic int base_of(input int g);
        case (g)
            int'(GRP_HI):  return BASE_HI;
            int'(GRP_DMA): return BASE_DMA;
            default:       return BASE_LO;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] bit_at_rank(input order_t o, input int r);
        return o[r*IDX_W +: IDX_W];
    endfunction

endpackage

// File: rtl/irq_grp_enc.sv
module irq_grp_enc
    import irq_prio_pkg::*;
#(
    parameter order_t ORDER = ORDER_HI,
    parameter int     BASE  = BASE_HI
) (
    input  logic [BANK_W-1:0] req,
    output grp_res_t          res
);

    localparam logic [ID_W-1:0] BASE_ID = ID_W'(BASE);

    // Walk from the lowest rank upward so the highest-ranked set bit is written last.
    always_comb begin
        res = '0;
        for (int r = BANK_W - 1; r >= 0; r--) begin
            if (req[bit_at_rank(ORDER, r)]) begin
                res.hit = 1'b1;
                res.id  = BASE_ID + ID_W'(bit_at_rank(ORDER, r));
            end
        end
    end

endmodule

// File: rtl/irq_grp_chain.sv
module irq_grp_chain
    import irq_prio_pkg::*;
(
    input  grp_res_t [NUM_BANKS-1:0] res,
    output logic     [ID_W-1:0]      id
);

    // The first group (lowest index) that saw any request decides, even with id zero.
    always_comb begin
        id = '0;
        for (int g = NUM_BANKS - 1; g >= 0; g--) begin
            if (res[g].hit) begin
                id = res[g].id;
            end
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] req_hi,
    input  logic [BANK_W-1:0] req_dma,
    input  logic [BANK_W-1:0] req_lo,
    output logic [ID_W-1:0]   irq_num,
    output logic              irq_valid
);

    logic     [NUM_BANKS-1:0][BANK_W-1:0] grp_req;
    grp_res_t [NUM_BANKS-1:0]             grp_res;
    logic     [ID_W-1:0]                  next_id;

    always_comb begin
        grp_req[GRP_HI]  = req_hi;
        grp_req[GRP_DMA] = req_dma;
        grp_req[GRP_LO]  = req_lo;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_grp
        irq_grp_enc #(
            .ORDER (order_of(g)),
            .BASE  (base_of(g))
        ) enc_i (
            .req (grp_req[g]),
            .res (grp_res[g])
        );
    end

    irq_grp_chain chain_i (
        .res (grp_res),
        .id  (next_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_num   <= '0;
            irq_valid <= 1'b0;
        end else begin
            irq_num   <= next_id;
            irq_valid <= |next_id;
        end
    end

endmodule

// File: rtl/irq_prio_enc_chk.sv
module irq_prio_enc_chk
    import irq_prio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BANK_W-1:0] req_hi,
    input logic [BANK_W-1:0] req_dma,
    input logic [BANK_W-1:0] req_lo,
    input logic [ID_W-1:0]   irq_num,
    input logic              irq_valid
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (irq_num == '0 && !irq_valid)); // R10

    AST_HI_WINS: assert property (@(posedge clk) disable iff (rst)
        (req_hi != '0) |=> (irq_num >= 5'd8 && irq_num <= 5'd15)); // R1

    AST_DMA_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req_hi == '0 && req_dma != '0) |=> (irq_num >= 5'd16 && irq_num <= 5'd23)); // R2

    AST_LO_LAST: assert property (@(posedge clk) disable iff (rst)
        (req_hi == '0 && req_dma == '0) |=> (irq_num <= 5'd7)); // R3

    AST_HI_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        req_hi[2] |=> (irq_num == 5'd10)); // R4

    AST_DMA_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        (req_hi == '0 && req_dma[0]) |=> (irq_num == 5'd16)); // R5

    AST_LO_TOP_BIT: assert property (@(posedge clk) disable iff (rst)
        (req_hi == '0 && req_dma == '0 && req_lo[7]) |=> (irq_num == 5'd7)); // R6

    AST_LO_ZERO_HIDES: assert property (@(posedge clk) disable iff (rst)
        (req_hi == '0 && req_dma == '0 && req_lo[0] && req_lo[7:2] == '0)
        |=> (irq_num == '0 && !irq_valid)); // R7

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(irq_num) |-> (irq_valid == (irq_num != '0))); // R8

endmodule

bind irq_prio_enc irq_prio_enc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_hi    (req_hi),
    .req_dma   (req_dma),
    .req_lo    (req_lo),
    .irq_num   (irq_num),
    .irq_valid (irq_valid)
);

// File: tb/irq_prio_enc_tb_top.sv
`timescale 1ns/1ps
module irq_prio_enc_tb_top;

    localparam time CLK_HALF = 10ns; // 50 MHz

    typedef struct {
        logic [4:0] num;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_hi = '0;
    logic [7:0] req_dma = '0;
    logic [7:0] req_lo = '0;
    logic [4:0] irq_num;
    logic       irq_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    int rank_hi[8]  = '{2, 3, 5, 7, 6, 0, 1, 4};
    int rank_dma[8] = '{0, 1, 2, 3, 5, 6, 7, 4};
    int rank_lo[8]  = '{7, 5, 3, 6, 2, 0, 1, 4};

    always #(CLK_HALF) clk = ~clk;

    irq_prio_enc dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_hi    (req_hi),
        .req_dma   (req_dma),
        .req_lo    (req_lo),
        .irq_num   (irq_num),
        .irq_valid (irq_valid)
    );

    function automatic logic [4:0] model(input logic [7:0] h, input logic [7:0] d,
                                          input logic [7:0] l);
        if (h != 0) begin
            for (int r = 0; r < 8; r++) if (h[rank_hi[r]]) return 5'(8 + rank_hi[r]);
        end
        if (d != 0) begin
            for (int r = 0; r < 8; r++) if (d[rank_dma[r]]) return 5'(16 + rank_dma[r]);
        end
        for (int r = 0; r < 8; r++) if (l[rank_lo[r]]) return 5'(rank_lo[r]);
        return 5'd0;
    endfunction

    function automatic string tag_of(input logic [7:0] h, input logic [7:0] d,
                                     input logic [7:0] l);
        if (h != 0) return "R1/R4";
        if (d != 0) return "R2/R5";
        if (l[0] && (l & 8'hEC) == 0) return "R7";
        return "R3/R6";
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp,
                         input logic gv, input logic ev);
        total++;
        if (got !== exp || gv !== ev) begin
            bad++;
            $display("FAIL %s: num=%0d valid=%0b expected num=%0d valid=%0b",
                     tag, got, gv, exp, ev);
        end
    endtask

    // Driver: change inputs on a falling edge and queue the expected result.
    task automatic drive(input logic [7:0] h, input logic [7:0] d, input logic [7:0] l);
        exp_t e;
        @(negedge clk);
        req_hi  = h;
        req_dma = d;
        req_lo  = l;
        e.num = model(h, d, l);
        e.tag = tag_of(h, d, l);
        sb_q.push_back(e);
    endtask

    // Monitor: the inputs driven before a rising edge show at the outputs after it (R9).
    initial begin
        forever begin
            @(posedge clk);
            #5ns;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " R8 R9"}, irq_num, e.num, irq_valid, e.num != 0);
            end
        end
    end

    initial begin
        #(CLK_HALF * 2 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: num=%0d valid=%0b expected num=0 valid=0", irq_num, irq_valid);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        req_hi = 8'hFF;
        req_dma = 8'hFF;
        req_lo = 8'hFF;
        repeat (2) @(posedge clk);
        #5ns;
        check("R10 reset", irq_num, 5'd0, irq_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        req_hi = '0;
        req_dma = '0;
        req_lo = '0;
        @(posedge clk);
        #5ns;
        check("R3 idle", irq_num, 5'd0, irq_valid, 1'b0);

        // Single bits of each group
        for (int b = 0; b < 8; b++) drive(8'(1 << b), 8'h00, 8'h00);
        for (int b = 0; b < 8; b++) drive(8'h00, 8'(1 << b), 8'h00);
        for (int b = 0; b < 8; b++) drive(8'h00, 8'h00, 8'(1 << b));

        // Adjacent ranks inside each group (R4, R5, R6)
        for (int r = 0; r < 7; r++)
            drive(8'((1 << rank_hi[r]) | (1 << rank_hi[r+1])), 8'h00, 8'h00);
        for (int r = 0; r < 7; r++)
            drive(8'h00, 8'((1 << rank_dma[r]) | (1 << rank_dma[r+1])), 8'h00);
        for (int r = 0; r < 7; r++)
            drive(8'h00, 8'h00, 8'((1 << rank_lo[r]) | (1 << rank_lo[r+1])));

        // Group precedence (R1, R2)
        drive(8'h10, 8'h01, 8'h80);
        drive(8'h00, 8'h10, 8'h80);
        drive(8'hFF, 8'hFF, 8'hFF);
        drive(8'h00, 8'hFF, 8'hFF);
        drive(8'h00, 8'h00, 8'hFF);

        // Low bit 0 hides bits 1 and 4 (R7)
        drive(8'h00, 8'h00, 8'h13);
        drive(8'h00, 8'h00, 8'h01);
        drive(8'h00, 8'h00, 8'h12);
        drive(8'h00, 8'h00, 8'h05);
        drive(8'h00, 8'h00, 8'h00);

        // Mid-run reset (R10)
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        rst = 1'b1;
        req_hi = 8'h04;
        @(posedge clk);
        #5ns;
        check("R10 mid-run reset", irq_num, 5'd0, irq_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // Pseudo-random, with groups forced empty at times
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] h, d, l;
            h = 8'($urandom);
            d = 8'($urandom);
            l = 8'($urandom);
            if (($urandom % 2) == 0) h = '0;
            if (($urandom % 3) == 0) d = '0;
            if (($urandom % 5) == 0) l = 8'(l & 8'h13);
            drive(h, d, l);
        end

        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule